// File: doc/BRIEF.md
# Duplex Compare-and-Vote Output Stage

This block is the output stage of a module that evaluates two copies of the same combinational function. It compares the two replica words every cycle. When they differ, it confines the error at once by forcing the module outputs into a configured safe state. Because two replicas alone cannot tell which one is wrong, a third opinion comes from an expected-output word held in a local latch. The pattern-scanning test path loads that latch. It also pulses a match strobe whenever the live inputs equal the stored input pattern that belongs to that expected word.

At the first match after a disagreement, the stage takes a two-of-three vote among the two replicas and the latched word. It disables the replica that loses the vote and drives the outputs from the survivor. Both replicas keep computing the whole time. The fault-location delay therefore depends on how often matches occur, not on a fixed timer. With n equiprobable inputs it averages about 2^n − 1 input periods.

A mode input selects one of four operating modes:
- full voting;
- compare-only, for when no stored patterns are available;
- single-replica with spot checks;
- survival, which replays the stored response on a match.

Top module: `dup_vote_stage`

## Requirements
- R1: In mode 0 (compare-only) and mode 1 (voting) with neither replica disabled, any difference between `rep_a_i` and `rep_b_i` raises `err_o` in the same cycle. The error stays latched until a vote resolves it or reset is applied.
- R2: The safe state is chosen by `safe_sel_i`. Code 0 drives z all-zeros and code 1 drives z all-ones. Code 2 drives `z_oe_o` low with z at zero. Code 3 holds the last value z carried in a cycle that was not in the safe state. `z_oe_o` is high for codes 0, 1 and 3. In mode 1 with neither replica disabled, z is in the safe state whenever `err_o` is high.
- R3: In mode 1 with neither replica disabled, at a cycle where `match_i` is high and exactly one replica equals the latched expected word, the other replica's disable flag sets at the next edge and `err_o` clears. Nothing is disabled before that first match, however long it takes.
- R4: In mode 1 with one replica disabled, z carries the surviving replica with `z_oe_o` high. The disabled replica's value has no effect on z.
- R5: The disable flags `dis_a_o` and `dis_b_o` are sticky until reset, and they are never both set.
- R6: In mode 1, `dbl_fault_o` sets at the next edge in two cases. The first is when, at a match, both replicas differ from the expected word while neither is disabled. The second is when the survivor differs from the expected word at a later match. Once set, `dbl_fault_o` stays set until reset. In mode 1 with `dbl_fault_o` set, `err_o` stays high and z stays in the safe state.
- R7: In mode 0, `match_i` is ignored and no replica is ever disabled. The error stays latched until reset, so z stays in the safe state even after the replicas agree again. Without an error, z carries `rep_a_i`.
- R8: In mode 2 (single-replica), z carries the survivor with `z_oe_o` high. The survivor is `rep_b_i` if `dis_a_o` is set, otherwise `rep_a_i`. Differences between the replicas are ignored. At a match where the survivor differs from the expected word, `err_o` rises in the same cycle. It stays high until the edge after a later match at which the survivor equals the expected word.
- R9: In mode 3 (survival), z carries the latched expected word with `z_oe_o` high in a cycle where `match_i` is high. In every other cycle, z is in the safe state.
- R10: While `exp_load_i` is high at a rising edge, the expected-word latch takes `exp_data_i`. The new value is in use from the next cycle on.
- R11: Reset is asserted asynchronously on a low `rst_n`, which clears all flags. Release takes effect after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 compare-only, 1 voting, 2 single-replica, 3 survival |
| safe_sel_i | input | 2 | Safe state: 0 zeros, 1 ones, 2 high-impedance, 3 hold |
| rep_a_i | input | WIDTH | Replica A output word |
| rep_b_i | input | WIDTH | Replica B output word |
| exp_load_i | input | 1 | Load strobe for the expected-word latch |
| exp_data_i | input | WIDTH | Expected word from the test path |
| match_i | input | 1 | Inputs equal the stored input pattern |
| z_o | output | WIDTH | Module output word |
| z_oe_o | output | 1 | Output enable (low models high impedance) |
| err_o | output | 1 | Error flag |
| dis_a_o | output | 1 | Replica A disabled |
| dis_b_o | output | 1 | Replica B disabled |
| dbl_fault_o | output | 1 | Both replicas judged faulty |

## Verification
The hardest situation to reach is a recovery that depends on when a match arrives rather than on elapsed time. The stimulus injects a single replica fault and then holds the match strobe low for differing stretches of cycles, checking that the flags and outputs stay in the confined state throughout. It then raises one match and checks that the disable flag and the clean output appear exactly one edge later. A second hard situation is the late double fault. The bench first drives a vote to disable one replica, then corrupts the survivor at a later match.

// File: rtl/dv_pkg.sv
package dv_pkg;
  typedef enum logic [1:0] {
    MODE_ALONE   = 2'd0,
    MODE_VOTE    = 2'd1,
    MODE_SINGLE  = 2'd2,
    MODE_SURVIVE = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    SAFE_ZERO = 2'd0,
    SAFE_ONE  = 2'd1,
    SAFE_HIZ  = 2'd2,
    SAFE_HOLD = 2'd3
  } safe_kind_e;
endpackage

// File: rtl/dv_vote_core.sv
module dv_vote_core #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  input  logic             dis_a_i,
  output logic             ab_diff_o,
  output logic             a_ok_o,
  output logic             b_ok_o,
  output logic [WIDTH-1:0] surv_o,
  output logic             surv_ok_o
);
  always_comb begin
    ab_diff_o = (a_i != b_i);
    a_ok_o    = (a_i == c_i);
    b_ok_o    = (b_i == c_i);
    surv_o    = dis_a_i ? b_i : a_i;
    surv_ok_o = dis_a_i ? b_ok_o : a_ok_o;
  end
endmodule

// File: rtl/dv_safe_gen.sv
module dv_safe_gen
  import dv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  safe_kind_e       kind_i,
  input  logic [WIDTH-1:0] hold_i,
  output logic [WIDTH-1:0] val_o,
  output logic             oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (kind_i)
        SAFE_ONE:  val_o[i] = 1'b1;
        SAFE_HOLD: val_o[i] = hold_i[i];
        default:   val_o[i] = 1'b0;
      endcase
    end
  end
  assign oe_o = (kind_i != SAFE_HIZ);
endmodule

// File: rtl/dv_fault_state.sv
module dv_fault_state
  import dv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode_i,
  input  logic     match_i,
  input  logic     ab_diff_i,
  input  logic     a_ok_i,
  input  logic     b_ok_i,
  input  logic     surv_ok_i,
  output logic     live_err_o,
  output logic     err_q_o,
  output logic     dis_a_q_o,
  output logic     dis_b_q_o,
  output logic     dbl_q_o
);
  logic err_d, dis_a_d, dis_b_d, dbl_d;
  logic none_dis;

  assign none_dis = !dis_a_q_o && !dis_b_q_o;

  always_comb begin
    case (mode_i)
      MODE_ALONE:  live_err_o = ab_diff_i;
      MODE_VOTE:   live_err_o = none_dis ? ab_diff_i : (match_i && !surv_ok_i);
      MODE_SINGLE: live_err_o = match_i && !surv_ok_i;
      default:     live_err_o = 1'b0;
    endcase
  end

  always_comb begin
    err_d   = err_q_o;
    dis_a_d = dis_a_q_o;
    dis_b_d = dis_b_q_o;
    dbl_d   = dbl_q_o;
    case (mode_i)
      MODE_ALONE: err_d = err_q_o || live_err_o;
      MODE_VOTE: begin
        if (dbl_q_o) begin
          err_d = 1'b1;
        end else if (none_dis) begin
          if (match_i && a_ok_i && !b_ok_i) begin
            dis_b_d = 1'b1;
            err_d   = 1'b0;
          end else if (match_i && b_ok_i && !a_ok_i) begin
            dis_a_d = 1'b1;
            err_d   = 1'b0;
          end else if (match_i && !a_ok_i && !b_ok_i) begin
            dbl_d = 1'b1;
            err_d = 1'b1;
          end else begin
            err_d = err_q_o || live_err_o;
          end
        end else if (match_i) begin
          err_d = !surv_ok_i;
          dbl_d = !surv_ok_i;
        end
      end
      MODE_SINGLE: if (match_i) err_d = !surv_ok_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q_o   <= 1'b0;
      dis_a_q_o <= 1'b0;
      dis_b_q_o <= 1'b0;
      dbl_q_o   <= 1'b0;
    end else begin
      err_q_o   <= err_d;
      dis_a_q_o <= dis_a_d;
      dis_b_q_o <= dis_b_d;
      dbl_q_o   <= dbl_d;
    end
  end
endmodule

// File: rtl/dup_vote_stage.sv
module dup_vote_stage
  import dv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       safe_sel_i,
  input  logic [WIDTH-1:0] rep_a_i,
  input  logic [WIDTH-1:0] rep_b_i,
  input  logic             exp_load_i,
  input  logic [WIDTH-1:0] exp_data_i,
  input  logic             match_i,
  output logic [WIDTH-1:0] z_o,
  output logic             z_oe_o,
  output logic             err_o,
  output logic             dis_a_o,
  output logic             dis_b_o,
  output logic             dbl_fault_o
);
  localparam int SyncDepth = 2;

  op_mode_e         mode;
  logic [SyncDepth-1:0] rsync_q;
  logic             rst_int_n;
  logic [WIDTH-1:0] exp_q, exp_d;
  logic [WIDTH-1:0] hold_q, hold_d;
  logic [WIDTH-1:0] surv, safe_val, drive_val;
  logic             safe_oe, use_safe;
  logic             ab_diff, a_ok, b_ok, surv_ok, live_err, err_q;

  assign mode = op_mode_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SyncDepth-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[SyncDepth-1];

  dv_vote_core #(.WIDTH(WIDTH)) u_vote (
    .a_i(rep_a_i), .b_i(rep_b_i), .c_i(exp_q), .dis_a_i(dis_a_o),
    .ab_diff_o(ab_diff), .a_ok_o(a_ok), .b_ok_o(b_ok),
    .surv_o(surv), .surv_ok_o(surv_ok)
  );

  dv_fault_state u_state (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode), .match_i(match_i),
    .ab_diff_i(ab_diff), .a_ok_i(a_ok), .b_ok_i(b_ok), .surv_ok_i(surv_ok),
    .live_err_o(live_err), .err_q_o(err_q), .dis_a_q_o(dis_a_o),
    .dis_b_q_o(dis_b_o), .dbl_q_o(dbl_fault_o)
  );

  dv_safe_gen #(.WIDTH(WIDTH)) u_safe (
    .kind_i(safe_kind_e'(safe_sel_i)), .hold_i(hold_q),
    .val_o(safe_val), .oe_o(safe_oe)
  );

  assign err_o = err_q || live_err;

  always_comb begin
    case (mode)
      MODE_ALONE:   begin use_safe = err_o;    drive_val = rep_a_i; end
      MODE_VOTE:    begin
        use_safe  = dbl_fault_o || ((!dis_a_o && !dis_b_o) ? err_o : live_err);
        drive_val = surv;
      end
      MODE_SINGLE:  begin use_safe = 1'b0;     drive_val = surv;    end
      default:      begin use_safe = !match_i; drive_val = exp_q;   end
    endcase
    z_o    = use_safe ? safe_val : drive_val;
    z_oe_o = use_safe ? safe_oe : 1'b1;
  end

  always_comb begin
    exp_d  = exp_load_i ? exp_data_i : exp_q;
    hold_d = use_safe ? hold_q : drive_val;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      exp_q  <= '0;
      hold_q <= '0;
    end else begin
      exp_q  <= exp_d;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/dv_checker.sv
module dv_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic [1:0]       safe_sel_i,
  input logic [WIDTH-1:0] rep_a_i,
  input logic [WIDTH-1:0] rep_b_i,
  input logic [WIDTH-1:0] exp_q,
  input logic             match_i,
  input logic [WIDTH-1:0] z_o,
  input logic             z_oe_o,
  input logic             err_o,
  input logic             dis_a_o,
  input logic             dis_b_o,
  input logic             dbl_fault_o
);
  a_r1_diff_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] == 1'b0 && !dis_a_o && !dis_b_o && rep_a_i != rep_b_i) |-> err_o);

  a_r2_hiz_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && !dis_a_o && !dis_b_o && err_o && safe_sel_i == 2'd2) |-> !z_oe_o);

  a_r3_vote_drops_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && !dis_a_o && !dis_b_o && !dbl_fault_o && match_i &&
     rep_a_i == exp_q && rep_b_i != exp_q) |=> dis_b_o);

  a_r5_disable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_a_o || dis_b_o) |=> (dis_a_o || dis_b_o));

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(dis_a_o && dis_b_o));

  a_r6_double_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_fault_o |=> dbl_fault_o);

  a_r7_alone_no_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && !dis_a_o && !dis_b_o) |=> (!dis_a_o && !dis_b_o));

  a_r9_survive_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3 && match_i) |-> (z_oe_o && z_o == exp_q));
endmodule

bind dup_vote_stage dv_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .safe_sel_i(safe_sel_i),
  .rep_a_i(rep_a_i), .rep_b_i(rep_b_i), .exp_q(exp_q), .match_i(match_i),
  .z_o(z_o), .z_oe_o(z_oe_o), .err_o(err_o), .dis_a_o(dis_a_o),
  .dis_b_o(dis_b_o), .dbl_fault_o(dbl_fault_o)
);

// File: tb/sim_dup_vote_stage.sv
`timescale 1ns/1ps
module sim_dup_vote_stage;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode, ssel;
  logic [W-1:0] ra, rb, cdata;
  logic cload, match;
  logic [W-1:0] z;
  logic zoe, err, disa, disb, dbl;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dup_vote_stage #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .safe_sel_i(ssel),
    .rep_a_i(ra), .rep_b_i(rb), .exp_load_i(cload), .exp_data_i(cdata),
    .match_i(match), .z_o(z), .z_oe_o(zoe), .err_o(err),
    .dis_a_o(disa), .dis_b_o(disb), .dbl_fault_o(dbl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt(); @(negedge clk); #1; endtask

  task automatic do_reset(input logic [1:0] m, input logic [1:0] s);
    rst_n = 1'b0; mode = m; ssel = s; ra = 8'h12; rb = 8'h12;
    cload = 1'b0; cdata = '0; match = 1'b0;
    nxt(); nxt();
    chk("R11 err in reset", err, 0);
    chk("R11 disables in reset", {disa, disb, dbl}, 0);
    rst_n = 1'b1;
    nxt(); nxt(); nxt();
  endtask

  task automatic load_c(input logic [W-1:0] v);
    cload = 1'b1; cdata = v; nxt(); cload = 1'b0; #1;
  endtask

  task automatic t_reset_clean();
    do_reset(2'd1, 2'd0);
    chk("R11 no error after release", err, 0);
    chk("R4 clean output passes A", {zoe, z}, {1'b1, 8'h12});
  endtask

  task automatic t_safe_states();
    do_reset(2'd1, 2'd3);
    ra = 8'h5A; rb = 8'h5A; nxt(); nxt();
    rb = 8'h5B; #1;
    chk("R1 same-cycle error", err, 1);
    chk("R2 hold keeps last good", {zoe, z}, {1'b1, 8'h5A});
    nxt();
    rb = 8'h5A; #1;
    chk("R1 error latched after agreement", err, 1);
    ssel = 2'd0; #1; chk("R2 zeros", {zoe, z}, {1'b1, 8'h00});
    ssel = 2'd1; #1; chk("R2 ones", {zoe, z}, {1'b1, 8'hFF});
    ssel = 2'd2; #1; chk("R2 hiz enable low", zoe, 0);
  endtask

  task automatic t_latency(input int wait_cyc, input bit fault_a);
    do_reset(2'd1, 2'd1);
    load_c(8'h33);
    ra = 8'h33; rb = 8'h33; nxt();
    chk("R10 loaded word used for clean", err, 0);
    if (fault_a) ra = 8'h30; else rb = 8'h30;
    for (int i = 0; i < wait_cyc; i++) nxt();
    chk("R3 nothing disabled before match", {disa, disb}, 0);
    chk("R2 confined while waiting", {zoe, z}, {1'b1, 8'hFF});
    match = 1'b1; nxt(); match = 1'b0; #1;
    chk("R3 faulty replica disabled at first match", {disa, disb}, fault_a ? 2'b10 : 2'b01);
    chk("R3 error cleared", err, 0);
    chk("R4 survivor drives z", {zoe, z}, {1'b1, 8'h33});
    if (fault_a) ra = 8'hC7; else rb = 8'hC7;
    #1;
    chk("R4 dead replica ignored", z, 8'h33);
    ra = 8'h33; rb = 8'h33; match = 1'b1; nxt(); match = 1'b0; #1;
    chk("R5 disable stays set", {disa, disb}, fault_a ? 2'b10 : 2'b01);
  endtask

  task automatic t_double_at_vote();
    do_reset(2'd1, 2'd0);
    load_c(8'h33);
    ra = 8'h10; rb = 8'h20; match = 1'b1; nxt(); match = 1'b0; #1;
    chk("R6 double fault raised", {dbl, err}, 2'b11);
    chk("R6 no disable on double", {disa, disb}, 0);
    ra = 8'h33; rb = 8'h33; nxt();
    chk("R6 safe kept", {zoe, z}, {1'b1, 8'h00});
  endtask

  task automatic t_double_late();
    do_reset(2'd1, 2'd0);
    load_c(8'h3C);
    ra = 8'h3C; rb = 8'h00; match = 1'b1; nxt(); match = 1'b0; #1;
    chk("R3 B dropped", disb, 1);
    ra = 8'h3D; match = 1'b1; #1;
    chk("R6 survivor mismatch safe", z, 8'h00);
    nxt(); match = 1'b0; #1;
    chk("R6 late double fault", {dbl, err}, 2'b11);
  endtask

  task automatic t_standalone();
    do_reset(2'd0, 2'd0);
    load_c(8'h11);
    ra = 8'h11; rb = 8'h12; match = 1'b1; nxt(); match = 1'b0; #1;
    chk("R7 no disable", {disa, disb}, 0);
    rb = 8'h11; nxt();
    chk("R7 error kept", err, 1);
    chk("R7 safe kept", z, 8'h00);
  endtask

  task automatic t_single();
    do_reset(2'd2, 2'd0);
    load_c(8'h44);
    ra = 8'h44; rb = 8'h99; nxt();
    chk("R8 replica diff ignored", {err, zoe, z}, {2'b01, 8'h44});
    ra = 8'h45; match = 1'b1; #1;
    chk("R8 immediate error", {err, z}, {1'b1, 8'h45});
    nxt(); match = 1'b0; #1;
    chk("R8 error latched", err, 1);
    ra = 8'h44; match = 1'b1; nxt(); match = 1'b0; #1;
    chk("R8 error cleared by good match", err, 0);
  endtask

  task automatic t_survival();
    do_reset(2'd3, 2'd0);
    load_c(8'h6C);
    chk("R9 no match safe", {zoe, z}, {1'b1, 8'h00});
    match = 1'b1; #1;
    chk("R9 replay", {zoe, z}, {1'b1, 8'h6C});
    match = 1'b0; ssel = 2'd1; #1;
    chk("R9 safe ones", z, 8'hFF);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_clean();
    t_safe_states();
    t_latency(5, 1'b0);
    t_latency(17, 1'b1);
    t_double_at_vote();
    t_double_late();
    t_standalone();
    t_single();
    t_survival();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule